// File: doc/BRIEF.md
# Calendar Counter with Maskable Alarm

This block holds a binary calendar (second, minute, hour, day of month, day of week, month, year) and advances it by one second whenever the tick input pulses. Carries ripple from seconds up to the year within the same cycle. Months count from 1, and the year is held as an offset from 2000, so the calendar spans 2000 to 2127.

A set of alarm registers mirrors the calendar fields. One cycle after each tick, the freshly advanced time is compared with the alarm. Any field whose mask bit is set is left out of the comparison. On a match with the alarm enabled, an alarm status flag is raised and an active-low level interrupt is asserted. Every tick also raises a tick status flag, which can drive the interrupt when enabled. Reading the status register clears it. In one-shot mode, the alarm disables itself when it fires.

Top module: `cal_alarm`

## Requirements
- R1: After reset the calendar reads second 0, minute 0, hour 0, day 1, weekday 0, month 1, year 0. Alarm, mask, enable and status registers read 0, and irq_n is high.
- R2: Each tick adds one second. Seconds roll over from 59 to 0 and carry into minutes. Minutes roll over from 59 to 0 and carry into hours. Hours roll over from 23 to 0 and carry into the day.
- R3: On a day carry the day of month returns to 1 once it has reached the month length, and otherwise increments. The month length is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11. For month 2 it is 29 when the year offset is divisible by 4 and 28 otherwise. On the same carry the weekday steps through 0 to 6 and wraps to 0.
- R4: A carry out of month 12 sets the month to 1 and increments the year. Year 127 wraps to 0.
- R5: The field index i runs 0 second, 1 minute, 2 hour, 3 day, 4 weekday, 5 month, 6 year. Calendar field i is at address 0x40+4i and alarm field i at 0x60+4i. Field widths are 6, 6, 5, 5, 3, 4 and 7 bits. A write keeps only the field's width, and a read returns the stored value in the low bits.
- R6: In the cycle after a tick, the new time is compared with the alarm. The mask register (0x10) excludes field i from the comparison when bit i is set, so bit 4 excludes the weekday. If every unmasked field matches and enable bit 0 is set, status bit 0 is set.
- R7: The alarm is evaluated only once per tick. A persisting match, or a time written by software, raises no alarm.
- R8: Status register 0x04 holds the alarm flag in bit 0 and the tick flag in bit 1. Every tick sets bit 1, whatever the enables are.
- R9: A read of 0x04 returns the current flags and clears them at that clock edge. An event in that same cycle is kept.
- R10: irq_n is low while status bit 0 is set, or while status bit 1 and enable bit 1 (0x08) are both set. Otherwise it is high.
- R11: When enable bit 2 is set, enable bit 0 clears itself as the alarm fires, so no later match raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per second |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe (clears status at 0x04) |
| addr | input | 7 | Register byte address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational from addr |
| irq_n | output | 1 | Level interrupt, active low |

## Verification
The status read-clear and a new tick or alarm event can land on the same clock edge. In that case the event must survive while the read still returns the old flags. The bench provokes this by raising tick and a status read in one cycle. It checks that the read data shows no flags and that the next read shows the tick flag. Alarm firing is also judged against persisting matches and software time writes, where it must stay silent.

// File: rtl/cal_alarm.sv
module cal_alarm #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr,
  input  logic          rd,
  input  logic [6:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_n
);
  localparam logic [6:0] A_STA = 7'h04;
  localparam logic [6:0] A_EN  = 7'h08;
  localparam logic [6:0] A_MSK = 7'h10;
  localparam logic [6:0] FM [0:6] = '{7'h3f, 7'h3f, 7'h1f, 7'h1f, 7'h07, 7'h0f, 7'h7f};

  logic [6:0] tm [0:6];
  logic [6:0] nt [0:6];
  logic [6:0] al [0:6];
  logic [6:0] msk;
  logic [2:0] en;
  logic [1:0] sta;
  logic       tick_d;
  logic       hit, fire;
  logic [6:0] mlen;
  logic [2:0] fidx;
  logic       tsel, asel;
  wire        unused_hi = &{1'b0, wdata[DW-1:7]};

  assign fidx = addr[4:2];
  assign tsel = addr[6:5] == 2'b10 && addr[1:0] == 2'b00 && fidx != 3'd7;
  assign asel = addr[6:5] == 2'b11 && addr[1:0] == 2'b00 && fidx != 3'd7;

  always_comb begin
    case (tm[5])
      7'd4, 7'd6, 7'd9, 7'd11: mlen = 7'd30;
      7'd2:                    mlen = (tm[6][1:0] == 2'b00) ? 7'd29 : 7'd28;
      default:                 mlen = 7'd31;
    endcase
  end

  always_comb begin
    nt = tm;
    if (tick) begin
      if (tm[0] >= 7'd59) begin
        nt[0] = 7'd0;
        if (tm[1] >= 7'd59) begin
          nt[1] = 7'd0;
          if (tm[2] >= 7'd23) begin
            nt[2] = 7'd0;
            nt[4] = (tm[4] >= 7'd6) ? 7'd0 : tm[4] + 7'd1;
            if (tm[3] >= mlen) begin
              nt[3] = 7'd1;
              if (tm[5] >= 7'd12) begin
                nt[5] = 7'd1;
                nt[6] = tm[6] + 7'd1;
              end else nt[5] = tm[5] + 7'd1;
            end else nt[3] = tm[3] + 7'd1;
          end else nt[2] = tm[2] + 7'd1;
        end else nt[1] = tm[1] + 7'd1;
      end else nt[0] = tm[0] + 7'd1;
    end
    if (wr && tsel) nt[fidx] = wdata[6:0] & FM[fidx];
  end

  always_comb begin
    hit = 1'b1;
    for (int i = 0; i < 7; i++)
      if (!msk[i] && tm[i] != al[i]) hit = 1'b0;
  end

  assign fire = tick_d && en[0] && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm     <= '{7'd0, 7'd0, 7'd0, 7'd1, 7'd0, 7'd1, 7'd0};
      al     <= '{default: 7'd0};
      msk    <= '0;
      en     <= '0;
      sta    <= '0;
      tick_d <= 1'b0;
    end else begin
      tm     <= nt;
      tick_d <= tick;
      if (wr && asel) al[fidx] <= wdata[6:0] & FM[fidx];
      if (wr && addr == A_MSK) msk <= wdata[6:0];
      if (wr && addr == A_EN) en <= wdata[2:0];
      else if (fire && en[2]) en[0] <= 1'b0;
      sta <= (rd && addr == A_STA) ? 2'b00 : sta;
      if (tick) sta[1] <= 1'b1;
      if (fire) sta[0] <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (tsel) rdata[6:0] = tm[fidx];
    else if (asel) rdata[6:0] = al[fidx];
    else if (addr == A_STA) rdata[1:0] = sta;
    else if (addr == A_EN) rdata[2:0] = en;
    else if (addr == A_MSK) rdata[6:0] = msk;
  end

  assign irq_n = !(sta[0] || (sta[1] && en[1]));
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr,
  input logic       rd_sta,
  input logic       wr_en,
  input logic [6:0] sec,
  input logic [1:0] sta,
  input logic [2:0] en,
  input logic       fire,
  input logic       irq_n
);
  p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && sec < 7'd59) |=> sec == $past(sec) + 7'd1);
  p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr) |=> $stable(sec));
  p_tick_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> sta[1]);
  p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sta && !tick && !fire) |=> sta == 2'b00);
  p_irq_alarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sta[0] |-> !irq_n);
  p_oneshot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && en[2] && !wr_en) |=> !en[0]);
endmodule

bind cal_alarm cal_alarm_chk chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr(wr),
  .rd_sta(rd && addr == 7'h04), .wr_en(wr && addr == 7'h08),
  .sec(tm[0]), .sta(sta), .en(en), .fire(fire), .irq_n(irq_n)
);

// File: tb/cal_alarm_test.sv
module cal_alarm_test;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0, tick = 0, wr = 0, rd = 0;
  logic [6:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  cal_alarm uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr(wr), .rd(rd),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic [3:0] rq;
    logic [6:0] s, mi, h, d, w, mo, y;
    logic [6:0] es, emi, eh, ed, ew, emo, ey;
  } vec_t;

  localparam vec_t VT [0:11] = '{
    '{4'd2, 7'd0,  7'd0,  7'd0,  7'd1,  7'd0, 7'd1,  7'd0,   7'd1,  7'd0,  7'd0,  7'd1,  7'd0, 7'd1, 7'd0},  // R2
    '{4'd2, 7'd59, 7'd0,  7'd0,  7'd1,  7'd0, 7'd1,  7'd0,   7'd0,  7'd1,  7'd0,  7'd1,  7'd0, 7'd1, 7'd0},  // R2
    '{4'd2, 7'd59, 7'd59, 7'd0,  7'd1,  7'd0, 7'd1,  7'd0,   7'd0,  7'd0,  7'd1,  7'd1,  7'd0, 7'd1, 7'd0},  // R2
    '{4'd3, 7'd59, 7'd59, 7'd23, 7'd1,  7'd2, 7'd1,  7'd0,   7'd0,  7'd0,  7'd0,  7'd2,  7'd3, 7'd1, 7'd0},  // R3
    '{4'd3, 7'd59, 7'd59, 7'd23, 7'd31, 7'd6, 7'd1,  7'd5,   7'd0,  7'd0,  7'd0,  7'd1,  7'd0, 7'd2, 7'd5},  // R3
    '{4'd3, 7'd59, 7'd59, 7'd23, 7'd30, 7'd3, 7'd4,  7'd5,   7'd0,  7'd0,  7'd0,  7'd1,  7'd4, 7'd5, 7'd5},  // R3
    '{4'd3, 7'd59, 7'd59, 7'd23, 7'd28, 7'd1, 7'd2,  7'd4,   7'd0,  7'd0,  7'd0,  7'd29, 7'd2, 7'd2, 7'd4},  // R3
    '{4'd3, 7'd59, 7'd59, 7'd23, 7'd29, 7'd2, 7'd2,  7'd4,   7'd0,  7'd0,  7'd0,  7'd1,  7'd3, 7'd3, 7'd4},  // R3
    '{4'd3, 7'd59, 7'd59, 7'd23, 7'd28, 7'd1, 7'd2,  7'd5,   7'd0,  7'd0,  7'd0,  7'd1,  7'd2, 7'd3, 7'd5},  // R3
    '{4'd4, 7'd59, 7'd59, 7'd23, 7'd31, 7'd4, 7'd12, 7'd9,   7'd0,  7'd0,  7'd0,  7'd1,  7'd5, 7'd1, 7'd10}, // R4
    '{4'd4, 7'd59, 7'd59, 7'd23, 7'd31, 7'd0, 7'd12, 7'd127, 7'd0,  7'd0,  7'd0,  7'd1,  7'd1, 7'd1, 7'd0},  // R4
    '{4'd2, 7'd30, 7'd59, 7'd23, 7'd15, 7'd2, 7'd6,  7'd20,  7'd31, 7'd59, 7'd23, 7'd15, 7'd2, 7'd6, 7'd20}  // R2
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [6:0] a, input logic [15:0] d);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rreg(input logic [6:0] a, output logic [15:0] d);
    rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 0;
  endtask

  task automatic do_tick();
    tick = 1;
    @(negedge clk);
    tick = 0;
    @(negedge clk);
  endtask

  task automatic set7(input logic [6:0] base, input logic [6:0] s, mi, h, d, w, mo, y);
    logic [6:0] f [0:6];
    f = '{s, mi, h, d, w, mo, y};
    for (int i = 0; i < 7; i++) wreg(base + 7'(4*i), {9'd0, f[i]});
  endtask

  logic [15:0] v;

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    begin
      logic [6:0] rv [0:6];
      rv = '{7'd0, 7'd0, 7'd0, 7'd1, 7'd0, 7'd1, 7'd0};
      for (int i = 0; i < 7; i++) begin
        rreg(7'h40 + 7'(4*i), v); chk("R1 time", v, {9'd0, rv[i]});
        rreg(7'h60 + 7'(4*i), v); chk("R1 alarm", v, 16'd0);
      end
    end
    rreg(7'h04, v); chk("R1 status", v, 16'd0);
    rreg(7'h08, v); chk("R1 enable", v, 16'd0);
    rreg(7'h10, v); chk("R1 mask", v, 16'd0);
    chk("R1 irq_n", {15'd0, irq_n}, 16'd1);

    // R2 R3 R4 table
    for (int k = 0; k < 12; k++) begin
      logic [6:0] ex [0:6];
      ex = '{VT[k].es, VT[k].emi, VT[k].eh, VT[k].ed, VT[k].ew, VT[k].emo, VT[k].ey};
      set7(7'h40, VT[k].s, VT[k].mi, VT[k].h, VT[k].d, VT[k].w, VT[k].mo, VT[k].y);
      do_tick();
      for (int i = 0; i < 7; i++) begin
        rreg(7'h40 + 7'(4*i), v);
        chk($sformatf("R%0d row %0d field %0d", VT[k].rq, k, i), v, {9'd0, ex[i]});
      end
    end

    // R5 truncation and alarm readback
    wreg(7'h48, 16'hffff); rreg(7'h48, v); chk("R5 hour width", v, 16'h1f);
    wreg(7'h70, 16'h00ff); rreg(7'h70, v); chk("R5 alarm weekday width", v, 16'h7);
    wreg(7'h74, 16'h0003); rreg(7'h74, v); chk("R5 alarm month", v, 16'h3);

    // R6 alarm fires on match
    set7(7'h40, 7'd30, 7'd20, 7'd10, 7'd15, 7'd2, 7'd6, 7'd20);
    set7(7'h60, 7'd31, 7'd20, 7'd10, 7'd15, 7'd2, 7'd6, 7'd20);
    rreg(7'h04, v);
    wreg(7'h08, 16'h1);
    do_tick();
    chk("R10 irq low on alarm", {15'd0, irq_n}, 16'd0);
    rreg(7'h04, v); chk("R6 R8 alarm and tick flags", v, 16'h3);
    chk("R9 irq released after read", {15'd0, irq_n}, 16'd1);
    rreg(7'h04, v); chk("R9 status cleared", v, 16'h0);

    // R6 mask: weekday mismatch
    wreg(7'h70, 16'h5);
    wreg(7'h40, 16'd30);
    do_tick();
    rreg(7'h04, v); chk("R6 unmasked weekday blocks", v, 16'h2);
    wreg(7'h10, 16'h10);
    wreg(7'h40, 16'd30);
    do_tick();
    rreg(7'h04, v); chk("R6 masked weekday matches", v, 16'h3);

    // R7 persisting match and software write
    repeat (4) @(negedge clk);
    rreg(7'h04, v); chk("R7 no refire on held match", v, 16'h0);
    wreg(7'h40, 16'd31);
    repeat (3) @(negedge clk);
    rreg(7'h04, v); chk("R7 write does not fire", v, 16'h0);
    chk("R7 irq high", {15'd0, irq_n}, 16'd1);

    // R8 R10 tick interrupt
    wreg(7'h08, 16'h0);
    do_tick();
    chk("R10 tick irq disabled", {15'd0, irq_n}, 16'd1);
    rreg(7'h04, v); chk("R8 tick flag without enable", v, 16'h2);
    wreg(7'h08, 16'h2);
    do_tick();
    chk("R10 tick irq enabled", {15'd0, irq_n}, 16'd0);
    rreg(7'h04, v); chk("R8 tick flag", v, 16'h2);
    chk("R10 tick irq released", {15'd0, irq_n}, 16'd1);

    // R9 read and tick in the same cycle
    tick = 1; rd = 1; addr = 7'h04;
    #1 chk("R9 read shows old flags", rdata, 16'h0);
    @(negedge clk);
    tick = 0; rd = 0;
    @(negedge clk);
    rreg(7'h04, v); chk("R9 same-cycle tick kept", v, 16'h2);

    // R11 one-shot
    wreg(7'h10, 16'h0);
    set7(7'h40, 7'd30, 7'd20, 7'd10, 7'd15, 7'd2, 7'd6, 7'd20);
    set7(7'h60, 7'd31, 7'd20, 7'd10, 7'd15, 7'd2, 7'd6, 7'd20);
    wreg(7'h08, 16'h5);
    rreg(7'h04, v);
    do_tick();
    rreg(7'h04, v); chk("R11 one-shot fires", v, 16'h3);
    rreg(7'h08, v); chk("R11 enable self-clears", v, 16'h4);
    wreg(7'h40, 16'd30);
    do_tick();
    rreg(7'h04, v); chk("R11 no second alarm", v, 16'h2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule